// File: doc/BRIEF.md
# Bit-plane frame buffer with serial video port

This block stores a one-bit-per-cell image as a grid of rows and columns held in on-chip flops. A random-access port reads or writes a single cell chosen by row and column. A fill engine paints a rectangle, given by two corner points and a value, with one row segment written per clock. A display path copies a whole row into a shift register in one cycle. A pixel enable then moves that row out one bit at a time as a serial stream.

The display path and the random-access path are decoupled. Once a row has been copied, later writes to the array do not disturb the bits still being streamed. While a fill is running, the random-access port is stalled. A row transfer is never stalled: it sees the array as it stands in the cycle the transfer is requested.

Top module: `fb_video_buffer`

## Requirements
- R1: After reset every cell holds 0, `fill_busy_o` is 0, `acc_ready_o` is 1, `acc_rvalid_o` is 0, `pix_empty_o` is 1 and `pix_o` is 0.
- R2: A request with `acc_req_i`=1, `acc_we_i`=1 and `acc_ready_o`=1 stores `acc_wdata_i` in the cell at (`acc_row_i`, `acc_col_i`) and leaves every other cell unchanged. It does not raise `acc_rvalid_o`.
- R3: A request with `acc_req_i`=1, `acc_we_i`=0 and `acc_ready_o`=1 returns the addressed cell on `acc_rdata_o`, with `acc_rvalid_o`=1, in the cycle after the clock edge that accepts it.
- R4: While `fill_busy_o` is 1, `acc_ready_o` is 0. Random-access requests made in that time write nothing and return no read data.
- R5: `fill_start_i` sampled while `fill_busy_o` is 0 sets every cell with column in [x-low, x-high] and row in [y-low, y-high], both bounds inclusive, to `fill_val_i`. Cells outside that region are unchanged. The fill writes one row per clock, from the lowest row upwards. `fill_busy_o` is 1 for exactly (y-high − y-low + 1) cycles, starting in the cycle after the start edge. A `fill_start_i` sampled while busy is ignored.
- R6: The corners are put in order before the fill begins, so that x0>x1 or y0>y1 covers the same region as the corners given in order.
- R7: `xfer_i` copies row `xfer_row_i` into the shift register at one clock edge, and `pix_empty_o` drops to 0 after that edge. Writes to the array after the transfer do not change the bits that are streamed out.
- R8: Each `pix_en_i` edge after a transfer puts the next bit on `pix_o`, starting with column 0. `pix_empty_o` rises at the same edge that outputs the last column. Enables that arrive while the shift register is empty output 0 and keep `pix_empty_o` at 1.
- R9: A transfer requested during a fill is performed at once. It captures the rows the fill wrote at earlier edges, but not the row the fill writes at the same edge.
- R10: When `xfer_i` and `pix_en_i` are both sampled at one edge, the load wins: `pix_o` goes to 0 and the next enable outputs column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_req_i | input | 1 | Random-access request |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_row_i | input | RW | Row of the accessed cell |
| acc_col_i | input | CW | Column of the accessed cell |
| acc_wdata_i | input | 1 | Write value |
| acc_ready_o | output | 1 | Port can accept a request |
| acc_rdata_o | output | 1 | Read data |
| acc_rvalid_o | output | 1 | Read data valid |
| fill_start_i | input | 1 | Start a rectangle fill |
| fill_x0_i | input | CW | First corner column |
| fill_y0_i | input | RW | First corner row |
| fill_x1_i | input | CW | Second corner column |
| fill_y1_i | input | RW | Second corner row |
| fill_val_i | input | 1 | Fill value |
| fill_busy_o | output | 1 | Fill in progress |
| xfer_i | input | 1 | Copy a row into the shift register |
| xfer_row_i | input | RW | Row to copy |
| pix_en_i | input | 1 | Pixel-rate shift enable |
| pix_o | output | 1 | Serial video bit |
| pix_empty_o | output | 1 | Shift register drained |

## Verification
Read data and every video bit are registered, so each is due one edge after the request or enable that causes it. The busy flag rises one edge after the start and stays high for one cycle per row of the region. The bench drives inputs on the falling edge and samples on the next falling edge, which is exactly one rising edge later. For fills, it counts the busy falling edges and compares the count with the row span. A transfer inside a fill is placed on a known busy cycle, so the row being written at that edge is known in advance. The array is checked through the read port one cell per cycle against a model that the bench keeps from the requirements.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;
endpackage

// File: rtl/fb_bit_array.sv
module fb_bit_array #(
  parameter int COLS = 64,
  parameter int ROWS = 64,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [RW-1:0]   wr_row_i,
  input  logic [COLS-1:0] wr_mask_i,
  input  logic            wr_val_i,
  input  logic            rd_en_i,
  input  logic [RW-1:0]   rd_row_i,
  input  logic [CW-1:0]   rd_col_i,
  output logic            rd_bit_o,
  output logic            rd_valid_o,
  input  logic [RW-1:0]   xfer_row_i,
  output logic [COLS-1:0] xfer_data_o
);
  logic [COLS-1:0] rows_q [ROWS];
  logic            rd_bit_q, rd_valid_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rows_q[r] <= '0;
      else if (wr_en_i && (wr_row_i == RW'(r)))
        rows_q[r] <= (rows_q[r] & ~wr_mask_i) | (wr_val_i ? wr_mask_i : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bit_q   <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_bit_q <= rows_q[rd_row_i][rd_col_i];
    end
  end

  assign rd_bit_o    = rd_bit_q;
  assign rd_valid_o  = rd_valid_q;
  // combinational row tap: a transfer sees contents before this edge's write
  assign xfer_data_o = rows_q[xfer_row_i];

  a_r3_read_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
endmodule

// File: rtl/fb_fill_engine.sv
module fb_fill_engine
  import fb_pkg::*;
#(
  parameter int COLS = 64,
  parameter int ROWS = 64,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CW-1:0]   x0_i,
  input  logic [RW-1:0]   y0_i,
  input  logic [CW-1:0]   x1_i,
  input  logic [RW-1:0]   y1_i,
  input  logic            val_i,
  output logic            busy_o,
  output logic            wr_en_o,
  output logic [RW-1:0]   wr_row_o,
  output logic [COLS-1:0] wr_mask_o,
  output logic            wr_val_o
);
  fill_state_e st_q;
  logic [CW-1:0] x_lo_q, x_hi_q;
  logic [RW-1:0] cur_y_q, y_hi_q;
  logic          val_q;
  logic          accept;

  assign accept = start_i && (st_q == FILL_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FILL_IDLE;
      x_lo_q  <= '0;
      x_hi_q  <= '0;
      cur_y_q <= '0;
      y_hi_q  <= '0;
      val_q   <= 1'b0;
    end else if (accept) begin
      st_q    <= FILL_RUN;
      x_lo_q  <= (x0_i > x1_i) ? x1_i : x0_i;
      x_hi_q  <= (x0_i > x1_i) ? x0_i : x1_i;
      cur_y_q <= (y0_i > y1_i) ? y1_i : y0_i;
      y_hi_q  <= (y0_i > y1_i) ? y0_i : y1_i;
      val_q   <= val_i;
    end else if (st_q == FILL_RUN) begin
      if (cur_y_q == y_hi_q) st_q <= FILL_IDLE;
      else cur_y_q <= cur_y_q + 1'b1;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_mask
    assign wr_mask_o[c] = ({1'b0, x_lo_q} <= (CW+1)'(c)) && ((CW+1)'(c) <= {1'b0, x_hi_q});
  end

  assign busy_o   = (st_q == FILL_RUN);
  assign wr_en_o  = busy_o;
  assign wr_row_o = cur_y_q;
  assign wr_val_o = val_q;

  a_r5_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r6_bounds_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (x_lo_q <= x_hi_q) && (cur_y_q <= y_hi_q));
  a_r5_busy_row_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(start_i)) |-> (cur_y_q == $past(cur_y_q) + 1'b1));
endmodule

// File: rtl/fb_row_shifter.sv
module fb_row_shifter #(
  parameter int COLS = 64,
  localparam int NW = $clog2(COLS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [COLS-1:0] load_data_i,
  input  logic            en_i,
  output logic            bit_o,
  output logic            empty_o
);
  logic [COLS-1:0] sreg_q;
  logic [NW-1:0]   left_q;
  logic            bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      left_q <= '0;
      bit_q  <= 1'b0;
    end else if (load_i) begin
      sreg_q <= load_data_i;
      left_q <= NW'(COLS);
      bit_q  <= 1'b0;
    end else if (en_i) begin
      if (left_q != '0) begin
        bit_q  <= sreg_q[0];
        sreg_q <= sreg_q >> 1;
        left_q <= left_q - 1'b1;
      end else begin
        bit_q  <= 1'b0;
      end
    end
  end

  assign bit_o   = bit_q;
  assign empty_o = (left_q == '0);

  a_r8_drained_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && en_i && !load_i) |=> (!bit_o && empty_o));
  a_r10_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!empty_o && !bit_o));
  a_r8_empty_after_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> $past(en_i));
endmodule

// File: rtl/fb_video_buffer.sv
module fb_video_buffer #(
  parameter int COLS = 64,
  parameter int ROWS = 64,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_req_i,
  input  logic          acc_we_i,
  input  logic [RW-1:0] acc_row_i,
  input  logic [CW-1:0] acc_col_i,
  input  logic          acc_wdata_i,
  output logic          acc_ready_o,
  output logic          acc_rdata_o,
  output logic          acc_rvalid_o,
  input  logic          fill_start_i,
  input  logic [CW-1:0] fill_x0_i,
  input  logic [RW-1:0] fill_y0_i,
  input  logic [CW-1:0] fill_x1_i,
  input  logic [RW-1:0] fill_y1_i,
  input  logic          fill_val_i,
  output logic          fill_busy_o,
  input  logic          xfer_i,
  input  logic [RW-1:0] xfer_row_i,
  input  logic          pix_en_i,
  output logic          pix_o,
  output logic          pix_empty_o
);
  logic            f_wr_en, f_wr_val, f_busy;
  logic [RW-1:0]   f_wr_row;
  logic [COLS-1:0] f_wr_mask;
  logic            rnd_we, rnd_re;
  logic [COLS-1:0] rnd_mask;
  logic            wr_en, wr_val;
  logic [RW-1:0]   wr_row;
  logic [COLS-1:0] wr_mask;
  logic [COLS-1:0] xfer_data;

  assign acc_ready_o = !f_busy;
  assign rnd_we      = acc_req_i && acc_we_i && acc_ready_o;
  assign rnd_re      = acc_req_i && !acc_we_i && acc_ready_o;
  assign rnd_mask    = {{(COLS-1){1'b0}}, 1'b1} << acc_col_i;

  // the two writers never overlap: the random port is stalled during a fill
  assign wr_en   = f_wr_en | rnd_we;
  assign wr_row  = f_wr_en ? f_wr_row  : acc_row_i;
  assign wr_mask = f_wr_en ? f_wr_mask : rnd_mask;
  assign wr_val  = f_wr_en ? f_wr_val  : acc_wdata_i;

  fb_fill_engine #(.COLS(COLS), .ROWS(ROWS)) u_fill (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (fill_start_i),
    .x0_i      (fill_x0_i),
    .y0_i      (fill_y0_i),
    .x1_i      (fill_x1_i),
    .y1_i      (fill_y1_i),
    .val_i     (fill_val_i),
    .busy_o    (f_busy),
    .wr_en_o   (f_wr_en),
    .wr_row_o  (f_wr_row),
    .wr_mask_o (f_wr_mask),
    .wr_val_o  (f_wr_val)
  );

  fb_bit_array #(.COLS(COLS), .ROWS(ROWS)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_row_i    (wr_row),
    .wr_mask_i   (wr_mask),
    .wr_val_i    (wr_val),
    .rd_en_i     (rnd_re),
    .rd_row_i    (acc_row_i),
    .rd_col_i    (acc_col_i),
    .rd_bit_o    (acc_rdata_o),
    .rd_valid_o  (acc_rvalid_o),
    .xfer_row_i  (xfer_row_i),
    .xfer_data_o (xfer_data)
  );

  fb_row_shifter #(.COLS(COLS)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (xfer_i),
    .load_data_i (xfer_data),
    .en_i        (pix_en_i),
    .bit_o       (pix_o),
    .empty_o     (pix_empty_o)
  );

  assign fill_busy_o = f_busy;

  a_r2_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rnd_we, f_wr_en}));
  a_r4_stall_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && !acc_we_i && fill_busy_o) |=> !acc_rvalid_o);
  a_r2_write_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && acc_we_i) |=> !acc_rvalid_o);
endmodule

// File: tb/fb_video_buffer_tb.sv
module fb_video_buffer_tb_top;
  localparam int COLS = 64;
  localparam int ROWS = 64;
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          acc_req = 0, acc_we = 0, acc_wdata = 0;
  logic [RW-1:0] acc_row = '0;
  logic [CW-1:0] acc_col = '0;
  logic          acc_ready, acc_rdata, acc_rvalid;
  logic          fill_start = 0, fill_val = 0, fill_busy;
  logic [CW-1:0] fx0 = '0, fx1 = '0;
  logic [RW-1:0] fy0 = '0, fy1 = '0;
  logic          xfer = 0, pix_en = 0, pix, pix_empty;
  logic [RW-1:0] xfer_row = '0;

  fb_video_buffer #(.COLS(COLS), .ROWS(ROWS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_req_i(acc_req), .acc_we_i(acc_we), .acc_row_i(acc_row), .acc_col_i(acc_col),
    .acc_wdata_i(acc_wdata), .acc_ready_o(acc_ready), .acc_rdata_o(acc_rdata),
    .acc_rvalid_o(acc_rvalid),
    .fill_start_i(fill_start), .fill_x0_i(fx0), .fill_y0_i(fy0), .fill_x1_i(fx1),
    .fill_y1_i(fy1), .fill_val_i(fill_val), .fill_busy_o(fill_busy),
    .xfer_i(xfer), .xfer_row_i(xfer_row), .pix_en_i(pix_en), .pix_o(pix),
    .pix_empty_o(pix_empty)
  );

  int total = 0, bad = 0;
  logic [COLS-1:0] model [ROWS];

  // vector: we, row, col, data
  localparam int NVEC = 10;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b1, 6'd0,  6'd0,  1'b1},
    {1'b1, 6'd63, 6'd63, 1'b1},
    {1'b1, 6'd5,  6'd17, 1'b1},
    {1'b1, 6'd5,  6'd18, 1'b1},
    {1'b1, 6'd5,  6'd17, 1'b0},
    {1'b0, 6'd0,  6'd0,  1'b0},
    {1'b0, 6'd63, 6'd63, 1'b0},
    {1'b0, 6'd5,  6'd17, 1'b0},
    {1'b0, 6'd5,  6'd18, 1'b0},
    {1'b0, 6'd5,  6'd19, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_bit(input int r, input int c, input bit d);
    acc_req = 1; acc_we = 1; acc_row = RW'(r); acc_col = CW'(c); acc_wdata = d;
    @(negedge clk);
    acc_req = 0; acc_we = 0;
    model[r][c] = d;
  endtask

  task automatic verify_array(input string tag);
    acc_req = 1; acc_we = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        acc_row = RW'(r); acc_col = CW'(c);
        @(negedge clk);
        chk(acc_rvalid && (acc_rdata == model[r][c]), tag, int'(acc_rdata), int'(model[r][c]));
      end
    acc_req = 0;
  endtask

  task automatic run_fill(input int x0, input int y0, input int x1, input int y1,
                          input bit v, input string tag);
    int cnt, lo, hi, xl, xh;
    fx0 = CW'(x0); fy0 = RW'(y0); fx1 = CW'(x1); fy1 = RW'(y1); fill_val = v;
    fill_start = 1;
    @(negedge clk);
    fill_start = 0;
    cnt = 0;
    while (fill_busy && cnt < 200) begin cnt++; @(negedge clk); end
    lo = (y0 < y1) ? y0 : y1; hi = (y0 < y1) ? y1 : y0;
    xl = (x0 < x1) ? x0 : x1; xh = (x0 < x1) ? x1 : x0;
    chk(cnt == hi - lo + 1, tag, cnt, hi - lo + 1);
    for (int r = lo; r <= hi; r++)
      for (int c = xl; c <= xh; c++) model[r][c] = v;
  endtask

  task automatic do_xfer(input int r);
    xfer = 1; xfer_row = RW'(r);
    @(negedge clk);
    xfer = 0;
    chk(!pix_empty && !pix, "R7 xfer clears empty", int'(pix_empty), 0);
  endtask

  task automatic stream_row(input logic [COLS-1:0] exp, input string tag);
    pix_en = 1;
    for (int c = 0; c < COLS; c++) begin
      @(negedge clk);
      chk(pix == exp[c], tag, int'(pix), int'(exp[c]));
      chk(pix_empty == (c == COLS-1), "R8 empty timing", int'(pix_empty), int'(c == COLS-1));
    end
    @(negedge clk);
    chk(!pix && pix_empty, "R8 drained outputs 0", int'(pix), 0);
    pix_en = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [COLS-1:0] old_row;
    int cnt;
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(acc_ready && !fill_busy && !acc_rvalid, "R1 reset flags", int'(fill_busy), 0);
    chk(pix_empty && !pix, "R1 reset video", int'(pix_empty), 1);
    pix_en = 1; @(negedge clk); pix_en = 0;
    chk(!pix && pix_empty, "R8 enable while empty after reset", int'(pix), 0);
    verify_array("R1 array clear");

    // R2 / R3 vector table
    for (int i = 0; i < NVEC; i++) begin
      acc_req = 1; acc_we = VEC[i][13]; acc_row = VEC[i][12:7];
      acc_col = VEC[i][6:1]; acc_wdata = VEC[i][0];
      @(negedge clk);
      if (VEC[i][13]) begin
        model[VEC[i][12:7]][VEC[i][6:1]] = VEC[i][0];
        chk(!acc_rvalid, "R2 write gives no rvalid", int'(acc_rvalid), 0);
      end else begin
        chk(acc_rvalid && acc_rdata == model[VEC[i][12:7]][VEC[i][6:1]], "R3 table read",
            int'(acc_rdata), int'(model[VEC[i][12:7]][VEC[i][6:1]]));
      end
    end
    acc_req = 0;
    @(negedge clk);
    chk(!acc_rvalid, "R3 rvalid one cycle", int'(acc_rvalid), 0);

    // R4 stall and ignored restart during a fill (rows 30..40 all columns)
    fx0 = 0; fy0 = 30; fx1 = 63; fy1 = 40; fill_val = 1; fill_start = 1;
    @(negedge clk);
    fill_start = 0;
    cnt = 0;
    while (fill_busy && cnt < 200) begin
      cnt++;
      if (cnt == 1) begin
        acc_req = 1; acc_we = 1; acc_row = 50; acc_col = 50; acc_wdata = 1;
        fx0 = 0; fy0 = 0; fx1 = 5; fy1 = 2; fill_start = 1;
      end else if (cnt == 2) begin
        chk(!acc_ready, "R4 ready low while busy", int'(acc_ready), 0);
        acc_we = 0; fill_start = 0;
      end else if (cnt == 3) begin
        chk(!acc_rvalid, "R4 stalled read no rvalid", int'(acc_rvalid), 0);
        acc_req = 0;
      end
      @(negedge clk);
    end
    chk(cnt == 11, "R5 busy length ignores restart", cnt, 11);
    for (int r = 30; r <= 40; r++) model[r] = '1;
    acc_req = 1; acc_we = 0; acc_row = 50; acc_col = 50;
    @(negedge clk);
    acc_req = 0;
    chk(acc_rvalid && !acc_rdata, "R4 stalled write dropped", int'(acc_rdata), 0);

    // R5 / R6 fills
    run_fill(40, 50, 20, 45, 1'b1, "R6 swapped corners busy");
    run_fill(10, 33, 12, 33, 1'b0, "R5 single-row clear");
    run_fill(63, 63, 63, 63, 1'b0, "R5 single-cell fill");
    verify_array("R5 R6 array after fills");

    // R7 stream holds copied row despite later writes
    do_xfer(30);
    wr_bit(30, 0, 1'b0);
    wr_bit(30, 63, 1'b0);
    stream_row({COLS{1'b1}}, "R7 streamed old row");

    // R10 load and enable together
    xfer = 1; xfer_row = 30; pix_en = 1;
    @(negedge clk);
    xfer = 0;
    chk(!pix && !pix_empty, "R10 load wins over enable", int'(pix), 0);
    stream_row(model[30], "R10 R8 stream from column 0");

    // R9 transfer during fill captures the row before this edge's write
    wr_bit(12, 7, 1'b1);
    old_row = model[12];
    fx0 = 3; fy0 = 10; fx1 = 60; fy1 = 20; fill_val = 1; fill_start = 1;
    @(negedge clk);
    fill_start = 0;
    cnt = 0;
    while (fill_busy && cnt < 200) begin
      cnt++;
      if (cnt == 3) begin xfer = 1; xfer_row = 12; end
      if (cnt == 4) begin
        xfer = 0;
        chk(!pix_empty, "R9 xfer granted during fill", int'(pix_empty), 0);
      end
      @(negedge clk);
    end
    chk(cnt == 11, "R5 busy length", cnt, 11);
    for (int r = 10; r <= 20; r++)
      for (int c = 3; c <= 60; c++) model[r][c] = 1'b1;
    stream_row(old_row, "R9 stream pre-fill row");
    do_xfer(11);
    stream_row(model[11], "R9 R8 stream filled row");
    verify_array("R5 array final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule